// File: doc/BRIEF.md
# Programmable Galois-Field CRC / LFSR Engine

This block keeps a single 32-bit Galois-field state register and uses it in one of two ways. In CRC mode it takes one data word per accepted handshake and folds all 32 bits of that word into the running remainder within one clock. It uses a polynomial that software can load. In PRNG mode the same register runs freely as a linear feedback shift register and emits pseudo-random data on every clock.

A bit-order select picks between two forms. The reflected form shifts right and takes bit 0 of each word first. The normal form shifts left and takes bit 31 of each word first. The same select governs how the polynomial and the state are read.

An external entropy bit can be mixed into the feedback. Mixing it slows the generator from one byte per clock to one bit per clock. The polynomial and the state are always visible at the outputs, and either one can be overwritten through a write strobe.

Top module: `gf_crc_lfsr_engine`

## Requirements
- R1: After reset the polynomial output reads 0xEDB88320 and the state output reads 0xFFFFFFFF. The CRC and PRNG enables read 0, and `done` and `rnd_valid` are both 0.
- R2: With the CRC enabled and `msb_first`=0, an accepted word updates the state in one clock, visible on the cycle after the handshake. Bits are taken from bit 0 up to bit 31. Each step is fb = state[0] ^ bit, then state = (state >> 1) ^ (fb ? poly : 0).
- R3: With the CRC enabled and `msb_first`=1, an accepted word updates the state in one clock. Bits are taken from bit 31 down to bit 0. Each step is fb = state[31] ^ bit, then state = (state << 1) ^ (fb ? poly : 0).
- R4: In reflected mode with the default polynomial, start from 0xFFFFFFFF and absorb the ASCII bytes "123456789", taking the lowest byte of each word first. The inverted state is then 0xCBF43926.
- R5: A control write that sets the PRNG enable leaves the CRC enable at 0, even if the same write requests the CRC enable.
- R6: A word presented while the CRC and PRNG are both disabled is ignored: the state is unchanged and `done` stays 0.
- R7: `done` is high for exactly the one cycle that follows each absorbed word, and is 0 otherwise.
- R8: With the PRNG enabled and entropy off, every clock advances the state by 8 zero-input steps under the selected bit order. `rnd_data` then shows bits [7:0] of the new state, with `rnd_valid` set to 1.
- R9: With the PRNG and entropy enabled, every clock advances the state by one step whose input bit is `ent_bit`. `rnd_data[0]` then shows bit 0 of the new state, `rnd_data[7:1]` reads 0, and `rnd_valid` is 1.
- R10: A state write takes priority over absorption and PRNG advance in the same cycle, and suppresses `done` and `rnd_valid`. A polynomial write takes effect for every later step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_crc_en | input | 1 | Requested CRC enable |
| ctrl_prng_en | input | 1 | Requested PRNG enable |
| ctrl_msb_first | input | 1 | Bit order: 1 = left shift, MSB first |
| ctrl_ent_en | input | 1 | Entropy mixing enable |
| poly_we | input | 1 | Polynomial write strobe |
| poly_wdata | input | 32 | Polynomial write value |
| state_we | input | 1 | State write strobe |
| state_wdata | input | 32 | State write value |
| din_valid | input | 1 | Data word valid |
| din_data | input | 32 | Data word |
| ent_bit | input | 1 | External entropy bit |
| poly_q | output | 32 | Current polynomial |
| state_q | output | 32 | CRC remainder or LFSR state |
| crc_en_q | output | 1 | CRC enable in force |
| prng_en_q | output | 1 | PRNG enable in force |
| done | output | 1 | One-cycle pulse after a word is absorbed |
| rnd_data | output | 8 | Pseudo-random output |
| rnd_valid | output | 1 | `rnd_data` is fresh |

## Verification
The bench builds the engine with its defaults: a 32-bit state and 8 PRNG steps per clock. These defaults make the standard check value of the reflected CRC-32 reachable as a fixed constant. They also let one model-computed vector table cover both bit orders, several seeds and a second polynomial. The byte-per-clock PRNG and the bit-per-clock entropy path are followed over several consecutive clocks, so any drift in step count or bit order shows up in the state output.

// File: rtl/gfe_pkg.sv
package gfe_pkg;

  typedef struct packed {
    logic crc_en;
    logic prng_en;
    logic msb_first;
    logic ent_en;
  } gfe_ctrl_t;

  localparam logic [31:0] GFE_POLY_DEFAULT = 32'hEDB88320;
  localparam logic [31:0] GFE_SEED_DEFAULT = 32'hFFFFFFFF;

endpackage

// File: rtl/gfe_ctrl.sv
module gfe_ctrl
  import gfe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic      crc_en_wr,
  input  logic      prng_en_wr,
  input  logic      msb_first_wr,
  input  logic      ent_en_wr,
  output gfe_ctrl_t ctrl
);

  // CRC request is refused whenever the same write turns the PRNG on
  logic crc_grant;
  assign crc_grant = crc_en_wr & ~prng_en_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (we) begin
      ctrl.crc_en    <= crc_grant;
      ctrl.prng_en   <= prng_en_wr;
      ctrl.msb_first <= msb_first_wr;
      ctrl.ent_en    <= ent_en_wr;
    end
  end

  // R5
  crc_prng_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.prng_en |-> !ctrl.crc_en);

  // R5
  crc_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.crc_en) |-> $past(we) && !$past(prng_en_wr));

endmodule

// File: rtl/gfe_state.sv
module gfe_state
  import gfe_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          RND_W    = 8,
  parameter logic [W-1:0] POLY_RST = W'(GFE_POLY_DEFAULT),
  parameter logic [W-1:0] SEED_RST = W'(GFE_SEED_DEFAULT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gfe_ctrl_t        ctrl,
  input  logic             poly_we,
  input  logic [W-1:0]     poly_wdata,
  input  logic             state_we,
  input  logic [W-1:0]     state_wdata,
  input  logic             din_valid,
  input  logic [W-1:0]     din_data,
  input  logic             ent_bit,
  output logic [W-1:0]     poly_q,
  output logic [W-1:0]     state_q,
  output logic             done,
  output logic [RND_W-1:0] rnd_data,
  output logic             rnd_valid
);

  localparam int PAD_W = RND_W - 1;

  // one Galois step; msb selects left-shift (normal) or right-shift (reflected)
  function automatic logic [W-1:0] gf_step(input logic [W-1:0] s,
                                           input logic [W-1:0] p,
                                           input logic b,
                                           input logic msb);
    logic fb;
    if (msb) begin
      fb = s[W-1] ^ b;
      gf_step = (s << 1) ^ (fb ? p : '0);
    end else begin
      fb = s[0] ^ b;
      gf_step = (s >> 1) ^ (fb ? p : '0);
    end
  endfunction

  function automatic logic [W-1:0] gf_absorb(input logic [W-1:0] s,
                                             input logic [W-1:0] p,
                                             input logic [W-1:0] d,
                                             input logic msb);
    logic [W-1:0] acc;
    acc = s;
    for (int i = 0; i < W; i++) begin
      acc = gf_step(acc, p, msb ? d[W-1-i] : d[i], msb);
    end
    gf_absorb = acc;
  endfunction

  function automatic logic [W-1:0] gf_free_run(input logic [W-1:0] s,
                                               input logic [W-1:0] p,
                                               input logic msb);
    logic [W-1:0] acc;
    acc = s;
    for (int i = 0; i < RND_W; i++) begin
      acc = gf_step(acc, p, 1'b0, msb);
    end
    gf_free_run = acc;
  endfunction

  // named internal events
  logic         absorb_ev;
  logic         prng_byte_ev;
  logic         prng_bit_ev;
  logic [W-1:0] absorb_nx;
  logic [W-1:0] byte_nx;
  logic [W-1:0] bit_nx;
  logic [W-1:0] state_nx;

  assign absorb_ev    = ctrl.crc_en & din_valid & ~state_we;
  assign prng_byte_ev = ctrl.prng_en & ~ctrl.ent_en & ~state_we;
  assign prng_bit_ev  = ctrl.prng_en & ctrl.ent_en & ~state_we;

  assign absorb_nx = gf_absorb(state_q, poly_q, din_data, ctrl.msb_first);
  assign byte_nx   = gf_free_run(state_q, poly_q, ctrl.msb_first);
  assign bit_nx    = gf_step(state_q, poly_q, ent_bit, ctrl.msb_first);

  always_comb begin
    if (state_we)          state_nx = state_wdata;
    else if (absorb_ev)    state_nx = absorb_nx;
    else if (prng_byte_ev) state_nx = byte_nx;
    else if (prng_bit_ev)  state_nx = bit_nx;
    else                   state_nx = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q    <= POLY_RST;
      state_q   <= SEED_RST;
      done      <= 1'b0;
      rnd_data  <= '0;
      rnd_valid <= 1'b0;
    end else begin
      if (poly_we) poly_q <= poly_wdata;
      state_q   <= state_nx;
      done      <= absorb_ev;
      rnd_valid <= prng_byte_ev | prng_bit_ev;
      if (prng_byte_ev)     rnd_data <= byte_nx[RND_W-1:0];
      else if (prng_bit_ev) rnd_data <= {{PAD_W{1'b0}}, bit_nx[0]};
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.crc_en && !ctrl.prng_en && !state_we) |=> $stable(state_q));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(din_valid) && $past(ctrl.crc_en) && !$past(state_we));

  // R8
  rnd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> $past(ctrl.prng_en));

  // R9
  ent_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && $past(ctrl.ent_en)) |-> (rnd_data[RND_W-1:1] == '0));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |=> (state_q == $past(state_wdata)) && !done && !rnd_valid);

endmodule

// File: rtl/gf_crc_lfsr_engine.sv
module gf_crc_lfsr_engine
  import gfe_pkg::*;
#(
  parameter int W     = 32,
  parameter int RND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ctrl_crc_en,
  input  logic             ctrl_prng_en,
  input  logic             ctrl_msb_first,
  input  logic             ctrl_ent_en,
  input  logic             poly_we,
  input  logic [W-1:0]     poly_wdata,
  input  logic             state_we,
  input  logic [W-1:0]     state_wdata,
  input  logic             din_valid,
  input  logic [W-1:0]     din_data,
  input  logic             ent_bit,
  output logic [W-1:0]     poly_q,
  output logic [W-1:0]     state_q,
  output logic             crc_en_q,
  output logic             prng_en_q,
  output logic             done,
  output logic [RND_W-1:0] rnd_data,
  output logic             rnd_valid
);

  gfe_ctrl_t ctrl;

  gfe_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (ctrl_we),
    .crc_en_wr    (ctrl_crc_en),
    .prng_en_wr   (ctrl_prng_en),
    .msb_first_wr (ctrl_msb_first),
    .ent_en_wr    (ctrl_ent_en),
    .ctrl         (ctrl)
  );

  gfe_state #(.W(W), .RND_W(RND_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .poly_we     (poly_we),
    .poly_wdata  (poly_wdata),
    .state_we    (state_we),
    .state_wdata (state_wdata),
    .din_valid   (din_valid),
    .din_data    (din_data),
    .ent_bit     (ent_bit),
    .poly_q      (poly_q),
    .state_q     (state_q),
    .done        (done),
    .rnd_data    (rnd_data),
    .rnd_valid   (rnd_valid)
  );

  assign crc_en_q  = ctrl.crc_en;
  assign prng_en_q = ctrl.prng_en;

  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (state_q == W'(GFE_SEED_DEFAULT)) || !rst_n || $past(state_we));

endmodule

// File: tb/sim_gf_crc_lfsr_engine.sv
module sim_gf_crc_lfsr_engine;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] P_DEF = 32'hEDB88320;
  localparam logic [31:0] P_ALT = 32'h04C11DB7;

  // {msb_first, seed, word}
  localparam logic [64:0] VEC [0:7] = '{
    {1'b0, 32'hFFFFFFFF, 32'h00000000},
    {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b0, 32'h12345678, 32'hDEADBEEF},
    {1'b0, 32'h00000000, 32'h00000001},
    {1'b1, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 32'hFFFFFFFF, 32'h80000000},
    {1'b1, 32'hA5A5A5A5, 32'h0F1E2D3C},
    {1'b1, 32'h00000000, 32'hCAFEF00D}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 0, ctrl_crc_en = 0, ctrl_prng_en = 0, ctrl_msb_first = 0, ctrl_ent_en = 0;
  logic        poly_we = 0, state_we = 0, din_valid = 0, ent_bit = 0;
  logic [31:0] poly_wdata = '0, state_wdata = '0, din_data = '0;
  logic [31:0] poly_q, state_q;
  logic        crc_en_q, prng_en_q, done, rnd_valid;
  logic [7:0]  rnd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_crc_lfsr_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_crc_en(ctrl_crc_en), .ctrl_prng_en(ctrl_prng_en),
    .ctrl_msb_first(ctrl_msb_first), .ctrl_ent_en(ctrl_ent_en),
    .poly_we(poly_we), .poly_wdata(poly_wdata),
    .state_we(state_we), .state_wdata(state_wdata),
    .din_valid(din_valid), .din_data(din_data), .ent_bit(ent_bit),
    .poly_q(poly_q), .state_q(state_q), .crc_en_q(crc_en_q), .prng_en_q(prng_en_q),
    .done(done), .rnd_data(rnd_data), .rnd_valid(rnd_valid)
  );

  // byte-wise reference, restated independently of the bit loop in the design
  function automatic logic [31:0] ref_word(input logic [31:0] c, input logic [31:0] p,
                                           input logic [31:0] d, input logic msb);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 4; k++) begin
      if (msb) begin
        r = r ^ {d[8*(3-k) +: 8], 24'h0};
        for (int j = 0; j < 8; j++) r = r[31] ? ((r << 1) ^ p) : (r << 1);
      end else begin
        r = r ^ {24'h0, d[8*k +: 8]};
        for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_byte_lsb(input logic [31:0] c, input logic [31:0] p,
                                               input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] ref_bit_lsb(input logic [31:0] c, input logic [31:0] p,
                                              input logic e);
    return (c >> 1) ^ ({32{c[0] ^ e}} & p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic crc, input logic prng, input logic msb, input logic ent);
    @(negedge clk);
    ctrl_we = 1; ctrl_crc_en = crc; ctrl_prng_en = prng; ctrl_msb_first = msb; ctrl_ent_en = ent;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic load_state(input logic [31:0] v);
    @(negedge clk);
    state_we = 1; state_wdata = v;
    @(negedge clk);
    state_we = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    din_valid = 1; din_data = w;
    @(negedge clk);
    din_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_s;
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 poly", poly_q, P_DEF);
    check("R1 state", state_q, 32'hFFFFFFFF);
    check("R1 flags", {28'h0, crc_en_q, prng_en_q, done, rnd_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3 vector table
    for (int v = 0; v < 8; v++) begin
      load_state(VEC[v][63:32]);
      set_ctrl(1'b1, 1'b0, VEC[v][64], 1'b0);
      push(VEC[v][31:0]);
      exp_s = ref_word(VEC[v][63:32], P_DEF, VEC[v][31:0], VEC[v][64]);
      check(VEC[v][64] ? "R3 msb-first word" : "R2 lsb-first word", state_q, exp_s);
      check("R7 done after absorb", {31'h0, done}, 32'h1);
      @(negedge clk);
      check("R7 done one cycle", {31'h0, done}, 32'h0);
    end

    // R4 check value: first byte folded by the bench, rest as two words
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    seed = ref_byte_lsb(32'hFFFFFFFF, P_DEF, 8'h31);
    load_state(seed);
    push(32'h35343332);
    push(32'h39383736);
    check("R4 check value", ~state_q, 32'hCBF43926);

    // R10 state write beats absorb
    @(negedge clk);
    din_valid = 1; din_data = 32'h11111111; state_we = 1; state_wdata = 32'h0BADCAFE;
    @(negedge clk);
    din_valid = 0; state_we = 0;
    check("R10 state write wins", state_q, 32'h0BADCAFE);
    check("R10 no done on write", {31'h0, done}, 32'h0);
    // R10 polynomial write used afterwards
    @(negedge clk);
    poly_we = 1; poly_wdata = P_ALT;
    @(negedge clk);
    poly_we = 0;
    check("R10 poly readback", poly_q, P_ALT);
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    push(32'h31323334);
    check("R10 alt poly msb", state_q, ref_word(32'h0BADCAFE, P_ALT, 32'h31323334, 1'b1));
    @(negedge clk);
    poly_we = 1; poly_wdata = P_DEF;
    @(negedge clk);
    poly_we = 0;

    // R6 word ignored while disabled
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    exp_s = state_q;
    push(32'h55AA55AA);
    check("R6 state held", state_q, exp_s);
    check("R6 no done", {31'h0, done}, 32'h0);

    // R5 blocked enable
    set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    check("R5 crc blocked", {31'h0, crc_en_q}, 32'h0);
    check("R5 prng on", {31'h0, prng_en_q}, 32'h1);
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

    // R8 byte per clock
    load_state(32'h89ABCDEF);
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    exp_s = state_q;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      for (int j = 0; j < 8; j++) exp_s = ref_bit_lsb(exp_s, P_DEF, 1'b0);
      check("R8 prng state", state_q, exp_s);
      check("R8 prng byte", {23'h0, rnd_valid, rnd_data}, {23'h0, 1'b1, exp_s[7:0]});
    end
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

    // R9 bit per clock with entropy
    load_state(32'h13579BDF);
    @(negedge clk);
    ent_bit = 1;
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b1);
    exp_s = state_q;
    for (int n = 0; n < 6; n++) begin
      ent_bit = n[0];
      @(negedge clk);
      exp_s = ref_bit_lsb(exp_s, P_DEF, n[0]);
      check("R9 entropy state", state_q, exp_s);
      check("R9 entropy bit", {23'h0, rnd_valid, rnd_data}, {23'h0, 1'b1, 7'h0, exp_s[0]});
    end
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule